// File: doc/BRIEF.md
# External Bus Chip-Select Sequencer

This block drives the address outputs and a group of active-low area selects for a non-multiplexed external memory bus. Every clock cycle the bus master offers one request: no access, an access to on-chip memory, or an access to one of several external areas. Which area an address belongs to is decided upstream and arrives as an index beside the address.

The sequencer registers its outputs and changes them only when the coming access needs it. An external access loads the address and selects its area. A further access to the same area moves the address while its select stays low. An access to another area swaps selects. An on-chip access releases every select but leaves the external address where it was. A cycle with no access changes nothing. Chained together, these rules let one select stay low for any number of cycles, which slow external devices can use to see a continuous enable.

Top module: `xbus_cs_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, every `cs_n` bit is 1 and `addr_out` is 0.
- R2: An external request (`req_valid`=1, `req_internal`=0) makes `addr_out` equal `req_addr` and drives only `cs_n[req_area]` low, both visible one clock after the request is sampled.
- R3: An external request for area j that follows an external access to area i (j differs from i) raises `cs_n[i]`, lowers `cs_n[j]` and loads the new address in the same cycle.
- R4: An internal request (`req_valid`=1, `req_internal`=1) after an external access sets every `cs_n` bit to 1 and leaves `addr_out` unchanged.
- R5: An external request for the area whose select is already low loads the new address and keeps that select low on both sides of the clock edge.
- R6: A cycle with `req_valid`=0 leaves `addr_out` and `cs_n` unchanged, including when a select is low.
- R7: At most one `cs_n` bit is low in any cycle.
- R8: An internal or idle request that comes after reset or after an internal access leaves `addr_out` unchanged and every `cs_n` bit at 1.
- R9: Any run of consecutive external accesses to one area keeps that area's select low for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | 1 when this cycle carries an access |
| req_internal | input | 1 | 1 when the access targets on-chip memory |
| req_area | input | 2 | Index of the external area addressed |
| req_addr | input | 24 | Address of the access |
| addr_out | output | 24 | Registered external address bus |
| cs_n | output | 4 | Registered area selects, active low, bit n for area n |

## Verification
A table of requests walks the sequencer through every pairing of one access kind with the next: external to the same area, to another area, to on-chip memory, and to no access, as well as on-chip and idle cycles with no select held. Each pairing tells apart whether the address, the select, both or neither should move. The distinction that matters is between releasing the select and freezing the address. Directed tests then hold one area through a long run of same-area accesses broken by idle cycles, and apply reset while a select is low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        KIND_IDLE     = 2'd0,
        KIND_INTERNAL = 2'd1,
        KIND_EXTERNAL = 2'd2
    } req_kind_e;

    function automatic req_kind_e classify(input logic valid, input logic internal);
        if (!valid)
            return KIND_IDLE;
        else if (internal)
            return KIND_INTERNAL;
        else
            return KIND_EXTERNAL;
    endfunction

endpackage

// File: rtl/xbus_area_tracker.sv
module xbus_area_tracker #(
    parameter int AREA_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  xbus_pkg::req_kind_e  kind,
    input  logic [AREA_W-1:0]    area_in,
    output logic                 held,
    output logic [AREA_W-1:0]    held_area
);
    import xbus_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_area <= '0;
        end else begin
            case (kind)
                KIND_EXTERNAL: begin
                    held      <= 1'b1;
                    held_area <= area_in;
                end
                KIND_INTERNAL: held <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
    parameter int NUM_AREAS = 4,
    parameter int AREA_W    = 2
) (
    input  logic                  held,
    input  logic [AREA_W-1:0]     held_area,
    output logic [NUM_AREAS-1:0]  cs_n
);
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_sel
        assign cs_n[g] = !(held && (held_area == AREA_W'(g)));
    end
endmodule

// File: rtl/xbus_addr_hold.sv
module xbus_addr_hold #(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  xbus_pkg::req_kind_e  kind,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic [ADDR_W-1:0]    addr_q
);
    import xbus_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (kind == KIND_EXTERNAL)
            addr_q <= addr_in;
    end
endmodule

// File: rtl/xbus_cs_sequencer.sv
module xbus_cs_sequencer #(
    parameter int ADDR_W    = 24,
    parameter int NUM_AREAS = 4,
    localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_internal,
    input  logic [AREA_W-1:0]     req_area,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic [ADDR_W-1:0]     addr_out,
    output logic [NUM_AREAS-1:0]  cs_n
);
    import xbus_pkg::*;

    req_kind_e          kind;
    logic               held;
    logic [AREA_W-1:0]  held_area;

    assign kind = classify(req_valid, req_internal);

    xbus_area_tracker #(.AREA_W(AREA_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .area_in   (req_area),
        .held      (held),
        .held_area (held_area)
    );

    xbus_cs_decode #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_dec (
        .held      (held),
        .held_area (held_area),
        .cs_n      (cs_n)
    );

    xbus_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .addr_in (req_addr),
        .addr_q  (addr_out)
    );
endmodule

// File: rtl/xbus_cs_sequencer_chk.sv
module xbus_cs_sequencer_chk #(
    parameter int ADDR_W    = 24,
    parameter int NUM_AREAS = 4,
    localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_internal,
    input logic [AREA_W-1:0]     req_area,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [ADDR_W-1:0]     addr_out,
    input logic [NUM_AREAS-1:0]  cs_n
);
    assert_single_select_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_external_load_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_internal) |=>
        (addr_out == $past(req_addr)) && (cs_n == ~(NUM_AREAS'(1) << $past(req_area))));

    assert_internal_release_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_internal) |=> (cs_n == '1) && $stable(addr_out));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(addr_out) && $stable(cs_n));

    assert_same_area_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_internal && !cs_n[req_area]) |=> !cs_n[$past(req_area)]);
endmodule

bind xbus_cs_sequencer xbus_cs_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_AREAS (NUM_AREAS)
) u_chk (.*);

// File: tb/tb_xbus_cs_sequencer.sv
module tb_xbus_cs_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int NUM_AREAS  = 4;
    localparam int AREA_W     = 2;

    typedef struct packed {
        logic              valid;
        logic              internal;
        logic [AREA_W-1:0] area;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        exp_cs;
        logic [ADDR_W-1:0] exp_addr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 24'h000000, 4'hF, 24'h000000}, // R8 idle after reset
        '{1'b1, 1'b1, 2'd0, 24'h111111, 4'hF, 24'h000000}, // R8 internal after reset
        '{1'b1, 1'b0, 2'd1, 24'h100010, 4'hD, 24'h100010}, // R2 first external
        '{1'b1, 1'b0, 2'd1, 24'h100014, 4'hD, 24'h100014}, // R5 same area
        '{1'b0, 1'b0, 2'd3, 24'hABCDEF, 4'hD, 24'h100014}, // R6 idle holds select
        '{1'b1, 1'b0, 2'd1, 24'h100018, 4'hD, 24'h100018}, // R5 same area again
        '{1'b1, 1'b0, 2'd3, 24'h300000, 4'h7, 24'h300000}, // R3 area swap
        '{1'b1, 1'b1, 2'd2, 24'h000400, 4'hF, 24'h300000}, // R4 internal releases
        '{1'b0, 1'b0, 2'd1, 24'h555555, 4'hF, 24'h300000}, // R8 idle after internal
        '{1'b1, 1'b0, 2'd0, 24'h000800, 4'hE, 24'h000800}, // R2 area 0
        '{1'b1, 1'b0, 2'd2, 24'h200004, 4'hB, 24'h200004}, // R3 area swap
        '{1'b0, 1'b1, 2'd0, 24'h777777, 4'hB, 24'h200004}, // R6 idle, internal flag ignored
        '{1'b1, 1'b1, 2'd0, 24'h999999, 4'hF, 24'h200004}  // R4 internal releases
    };
    localparam string TAGS [NV] = '{"R8","R8","R2","R5","R6","R5","R3","R4","R8","R2","R3","R6","R4"};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_internal = 1'b0;
    logic [AREA_W-1:0] req_area = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [3:0]        cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_cs_sequencer #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_internal(req_internal),
        .req_area(req_area), .req_addr(req_addr), .addr_out(addr_out), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [3:0] ecs, input logic [ADDR_W-1:0] ead);
        checks++;
        if (cs_n !== ecs || addr_out !== ead) begin
            errors++;
            $display("FAIL %s: cs_n=%h addr_out=%h expected cs_n=%h addr_out=%h",
                     tag, cs_n, addr_out, ecs, ead);
        end
        checks++;
        if ($countones(~cs_n) > 1) begin
            errors++;
            $display("FAIL R7: cs_n=%h has %0d low bits, expected at most 1",
                     cs_n, $countones(~cs_n));
        end
    endtask

    task automatic step(input logic v, input logic i, input logic [AREA_W-1:0] a,
                        input logic [ADDR_W-1:0] ad);
        @(negedge clk);
        req_valid = v; req_internal = i; req_area = a; req_addr = ad;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check("R1", 4'hF, 24'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", 4'hF, 24'h0);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].valid, VECS[k].internal, VECS[k].area, VECS[k].addr);
            check(TAGS[k], VECS[k].exp_cs, VECS[k].exp_addr);
        end

        // R9: long run on area 2 with idle gaps, select never rises
        for (int k = 0; k < 40; k++) begin
            if (k % 5 == 4) begin
                step(1'b0, 1'b0, 2'd1, 24'hFFFFFF);
                check("R9", 4'hB, 24'h200000 + 24'(4*(k-1)));
            end else begin
                step(1'b1, 1'b0, 2'd2, 24'h200000 + 24'(4*k));
                check("R9", 4'hB, 24'h200000 + 24'(4*k));
            end
        end

        // R1: reset while a select is held low
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b1; req_internal = 1'b0; req_area = 2'd3; req_addr = 24'h3FFFFF;
        @(posedge clk);
        #2;
        check("R1", 4'hF, 24'h0);
        @(negedge clk);
        rst = 1'b0; req_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R1", 4'hF, 24'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule